// File: doc/BRIEF.md
# Prioritized Pending Interrupt Selector

This block keeps one pending flag for each of thirteen asynchronous interrupt causes of a processor core. From these flags and the core's current enable state (the external-enable bit, the critical-enable bit, whether the core runs in hypervisor mode) plus some control inputs, it picks at most one cause at a time. It presents that cause as a code with a valid strobe until the exception entry logic accepts it. On acceptance it clears the flag of the cause that was taken, unless that cause is one whose flag is owned by its source.

Doorbell messages arriving from other cores are decoded into the two doorbell flags. A message is honoured when it is broadcast or when its tag equals this core's identifier. A power-save entry pulse throws away a waiting hypervisor decrementer request. The exception entry sequence itself lives outside the block.

Cause codes and their fixed priority (0 is the highest): 0 reset, 1 machine check, 2 hypervisor decrementer, 3 external, 4 critical external, 5 watchdog, 6 critical doorbell, 7 fixed-interval timer, 8 programmable-interval timer, 9 decrementer, 10 doorbell, 11 performance monitor, 12 thermal. Bit i of `src_set_i` and `src_clr_i` belongs to cause code i.

Top module: `intr_select`

## Requirements
- R1: After reset no flag is pending. `take_valid_o` and `req_active_o` are 0. A 1 on bit i of `src_set_i` at a clock edge sets flag i, and a 1 on bit i of `src_clr_i` clears it. When both are 1 in the same cycle, the set wins.
- R2: Among the eligible pending causes the lowest code is presented. Reset (0) and machine check (1) are eligible whatever the enables are.
- R3: The hypervisor decrementer (2) is eligible only when `hdec_en_i` is 1 and either `ee_i` is 1 or `hv_mode_i` is 0.
- R4: The external cause (3) is eligible when `ee_i` is 1. It is also eligible when `hv_cap_i` is 1, `hv_mode_i` is 0 and `ext_route_i` is 0.
- R5: Critical external (4) is eligible only when `ce_i` is 1. Causes 5 to 12 are eligible only when `ee_i` is 1.
- R6: Acceptance clears the flag of the taken cause for codes 0, 1, 2, 5, 6, 7, 8, 10, 11 and 12. The flags of external (3) and critical external (4) stay set, so these causes are presented again.
- R7: Acceptance of the decrementer (9) clears its flag only when `dec_clr_take_i` is 1.
- R8: A 1 on `pwr_save_i` at a clock edge clears the hypervisor decrementer flag. It wins over a set in the same cycle.
- R9: On `msg_valid_i`, message type 0 addresses the doorbell flag (10) and type 1 the critical doorbell flag (6). Every other type is ignored. The message applies only when `msg_bcast_i` is 1 or `msg_tag_i` equals `core_id_i`. With `msg_clear_i` 0 it sets the addressed flag, and with 1 it clears it.
- R10: While `take_valid_o` is 1 and `take_ready_i` is 0, the valid strobe and `take_code_o` hold. The cycle after an acceptance (valid and ready both 1 at an edge), valid is 0. The next selection uses the flags as updated by that acceptance.
- R11: `req_active_o` is 1 exactly while at least one flag is pending, and it falls to 0 once all flags are clear.
- R12: When the selector is idle, a cause set at clock edge k and eligible is presented with valid 1 from edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_set_i | input | 13 | Per-cause set pulses, bit i = code i |
| src_clr_i | input | 13 | Per-cause clear pulses, bit i = code i |
| ee_i | input | 1 | External-enable state bit |
| ce_i | input | 1 | Critical-enable state bit |
| hv_mode_i | input | 1 | Core is in hypervisor mode |
| hv_cap_i | input | 1 | Core has hypervisor support |
| ext_route_i | input | 1 | Partition external-routing control bit |
| hdec_en_i | input | 1 | Hypervisor decrementer enable control |
| dec_clr_take_i | input | 1 | Decrementer flag cleared on acceptance |
| pwr_save_i | input | 1 | Power-save entry pulse |
| msg_valid_i | input | 1 | Doorbell message strobe |
| msg_clear_i | input | 1 | Message is a clear (1) or a set (0) |
| msg_type_i | input | 3 | Message type: 0 doorbell, 1 critical doorbell |
| msg_bcast_i | input | 1 | Message is broadcast |
| msg_tag_i | input | 8 | Target core tag of the message |
| core_id_i | input | 8 | This core's identifier |
| take_ready_i | input | 1 | Exception entry accepts the presented cause |
| take_valid_o | output | 1 | A cause is presented |
| take_code_o | output | 4 | Code of the presented cause |
| req_active_o | output | 1 | At least one flag is pending |

## Verification
Every cycle, the assertions check the presentation handshake: a held code stays stable, and valid drops for the cycle after an acceptance. They also check that reset and then machine check win whenever they are pending. They check that any hypervisor decrementer, critical external or low-priority cause that gets presented had its enable conditions true in the previous cycle, and that the power-save pulse empties the hypervisor decrementer flag. The full priority ladder, which causes survive acceptance, the decrementer configuration, the doorbell tag and type decoding, and the one-cycle latency can only be shown by the bench's directed scenarios, which observe the sequence of presented codes.

// File: rtl/intr_sel_pkg.sv
package intr_sel_pkg;
  localparam int NSRC   = 13;
  localparam int CODE_W = $clog2(NSRC);

  // cause codes, lower value is higher priority
  localparam int C_RST   = 0;
  localparam int C_MCHK  = 1;
  localparam int C_HDEC  = 2;
  localparam int C_EXT   = 3;
  localparam int C_CEXT  = 4;
  localparam int C_WDOG  = 5;
  localparam int C_CDBL  = 6;
  localparam int C_FIT   = 7;
  localparam int C_PIT   = 8;
  localparam int C_DEC   = 9;
  localparam int C_DBL   = 10;
  localparam int C_PERF  = 11;
  localparam int C_THERM = 12;

  // message types for doorbells
  localparam int MT_DBL  = 0;
  localparam int MT_CDBL = 1;
endpackage

// File: rtl/intr_pend_reg.sv
module intr_pend_reg #(
  parameter int N = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_q;
  logic [N-1:0] pend_d;
  logic         upd_en;

  always_comb begin
    upd_en = (|set_i) | (|clr_i);
    pend_d = (pend_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (upd_en) begin
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/intr_dbell_dec.sv
module intr_dbell_dec
  import intr_sel_pkg::*;
#(
  parameter int TAG_W  = 8,
  parameter int TYPE_W = 3
) (
  input  logic              msg_valid_i,
  input  logic              msg_clear_i,
  input  logic [TYPE_W-1:0] msg_type_i,
  input  logic              msg_bcast_i,
  input  logic [TAG_W-1:0]  msg_tag_i,
  input  logic [TAG_W-1:0]  core_id_i,
  output logic [NSRC-1:0]   set_o,
  output logic [NSRC-1:0]   clr_o
);
  logic           hit;
  logic [NSRC-1:0] target;

  always_comb begin
    hit    = msg_valid_i & (msg_bcast_i | (msg_tag_i == core_id_i));
    target = '0;
    if (msg_type_i == TYPE_W'(MT_DBL))  target[C_DBL]  = 1'b1;
    if (msg_type_i == TYPE_W'(MT_CDBL)) target[C_CDBL] = 1'b1;
    set_o = (hit & ~msg_clear_i) ? target : '0;
    clr_o = (hit &  msg_clear_i) ? target : '0;
  end
endmodule

// File: rtl/intr_gate.sv
module intr_gate
  import intr_sel_pkg::*;
(
  input  logic [NSRC-1:0] pend_i,
  input  logic            ee_i,
  input  logic            ce_i,
  input  logic            hv_mode_i,
  input  logic            hv_cap_i,
  input  logic            ext_route_i,
  input  logic            hdec_en_i,
  output logic [NSRC-1:0] elig_o
);
  logic [NSRC-1:0] allow;

  always_comb begin
    allow          = {NSRC{ee_i}};
    allow[C_RST]   = 1'b1;
    allow[C_MCHK]  = 1'b1;
    allow[C_HDEC]  = hdec_en_i & (ee_i | ~hv_mode_i);
    allow[C_EXT]   = ee_i | (hv_cap_i & ~hv_mode_i & ~ext_route_i);
    allow[C_CEXT]  = ce_i;
    elig_o         = pend_i & allow;
  end
endmodule

// File: rtl/intr_prio.sv
module intr_prio #(
  parameter int N = 13,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] req_i,
  output logic         any_o,
  output logic [W-1:0] idx_o
);
  logic [N:0] seen;
  logic [W-1:0] part [N+1];

  assign seen[0] = 1'b0;
  assign part[0] = '0;

  for (genvar g = 0; g < N; g++) begin : g_chain
    assign seen[g+1] = seen[g] | req_i[g];
    assign part[g+1] = (req_i[g] & ~seen[g]) ? W'(g) : part[g];
  end

  assign any_o = seen[N];
  assign idx_o = part[N];
endmodule

// File: rtl/intr_select.sv
module intr_select
  import intr_sel_pkg::*;
#(
  parameter int TAG_W  = 8,
  parameter int TYPE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_set_i,
  input  logic [NSRC-1:0]   src_clr_i,
  input  logic              ee_i,
  input  logic              ce_i,
  input  logic              hv_mode_i,
  input  logic              hv_cap_i,
  input  logic              ext_route_i,
  input  logic              hdec_en_i,
  input  logic              dec_clr_take_i,
  input  logic              pwr_save_i,
  input  logic              msg_valid_i,
  input  logic              msg_clear_i,
  input  logic [TYPE_W-1:0] msg_type_i,
  input  logic              msg_bcast_i,
  input  logic [TAG_W-1:0]  msg_tag_i,
  input  logic [TAG_W-1:0]  core_id_i,
  input  logic              take_ready_i,
  output logic              take_valid_o,
  output logic [CODE_W-1:0] take_code_o,
  output logic              req_active_o
);
  logic [NSRC-1:0]   pend_q;
  logic [NSRC-1:0]   elig;
  logic [NSRC-1:0]   msg_set;
  logic [NSRC-1:0]   msg_clr;
  logic [NSRC-1:0]   take_clr;
  logic [NSRC-1:0]   clr_on_take;
  logic [NSRC-1:0]   all_set;
  logic [NSRC-1:0]   all_clr;
  logic              pick_any;
  logic [CODE_W-1:0] pick_idx;
  logic              accept;
  logic              valid_q, valid_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic              out_en;

  intr_dbell_dec #(.TAG_W(TAG_W), .TYPE_W(TYPE_W)) u_dbell (
    .msg_valid_i (msg_valid_i),
    .msg_clear_i (msg_clear_i),
    .msg_type_i  (msg_type_i),
    .msg_bcast_i (msg_bcast_i),
    .msg_tag_i   (msg_tag_i),
    .core_id_i   (core_id_i),
    .set_o       (msg_set),
    .clr_o       (msg_clr)
  );

  // which causes lose their flag when accepted
  always_comb begin
    clr_on_take         = '1;
    clr_on_take[C_EXT]  = 1'b0;
    clr_on_take[C_CEXT] = 1'b0;
    clr_on_take[C_DEC]  = dec_clr_take_i;
  end

  assign accept = valid_q & take_ready_i;

  for (genvar g = 0; g < NSRC; g++) begin : g_take_clr
    assign take_clr[g] = accept & (code_q == CODE_W'(g)) & clr_on_take[g];
  end

  always_comb begin
    all_set         = src_set_i | msg_set;
    all_set[C_HDEC] = all_set[C_HDEC] & ~pwr_save_i;
    all_clr         = src_clr_i | msg_clr | take_clr;
    all_clr[C_HDEC] = all_clr[C_HDEC] | pwr_save_i;
  end

  intr_pend_reg #(.N(NSRC)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (all_set),
    .clr_i  (all_clr),
    .pend_o (pend_q)
  );

  intr_gate u_gate (
    .pend_i      (pend_q),
    .ee_i        (ee_i),
    .ce_i        (ce_i),
    .hv_mode_i   (hv_mode_i),
    .hv_cap_i    (hv_cap_i),
    .ext_route_i (ext_route_i),
    .hdec_en_i   (hdec_en_i),
    .elig_o      (elig)
  );

  intr_prio #(.N(NSRC)) u_prio (
    .req_i (elig),
    .any_o (pick_any),
    .idx_o (pick_idx)
  );

  // presentation stage: hold until accepted, one idle cycle after acceptance
  always_comb begin
    valid_d = valid_q;
    code_d  = code_q;
    out_en  = 1'b0;
    if (valid_q) begin
      if (take_ready_i) begin
        valid_d = 1'b0;
        out_en  = 1'b1;
      end
    end else if (pick_any) begin
      valid_d = 1'b1;
      code_d  = pick_idx;
      out_en  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      code_q  <= '0;
    end else if (out_en) begin
      valid_q <= valid_d;
      code_q  <= code_d;
    end
  end

  assign take_valid_o = valid_q;
  assign take_code_o  = code_q;
  assign req_active_o = |pend_q;
endmodule

// File: rtl/intr_select_chk.sv
module intr_select_chk
  import intr_sel_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [NSRC-1:0]   pend,
  input logic              ee_i,
  input logic              ce_i,
  input logic              hv_mode_i,
  input logic              hdec_en_i,
  input logic              pwr_save_i,
  input logic              take_ready_i,
  input logic              take_valid_o,
  input logic [CODE_W-1:0] take_code_o
);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid_o && !take_ready_i |=> take_valid_o && $stable(take_code_o));

  p_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid_o && take_ready_i |=> !take_valid_o);

  p_rst_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pend[C_RST] && !take_valid_o |=> take_valid_o && take_code_o == CODE_W'(C_RST));

  p_mchk_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pend[C_MCHK] && !pend[C_RST] && !take_valid_o
      |=> take_valid_o && take_code_o == CODE_W'(C_MCHK));

  p_hdec_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(take_valid_o) && take_code_o == CODE_W'(C_HDEC)
      |-> $past(hdec_en_i && (ee_i || !hv_mode_i)));

  p_cext_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(take_valid_o) && take_code_o == CODE_W'(C_CEXT) |-> $past(ce_i));

  p_low_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(take_valid_o) && take_code_o >= CODE_W'(C_WDOG) |-> $past(ee_i));

  p_pwr_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_save_i |=> !pend[C_HDEC]);
endmodule

bind intr_select intr_select_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pend         (pend_q),
  .ee_i         (ee_i),
  .ce_i         (ce_i),
  .hv_mode_i    (hv_mode_i),
  .hdec_en_i    (hdec_en_i),
  .pwr_save_i   (pwr_save_i),
  .take_ready_i (take_ready_i),
  .take_valid_o (take_valid_o),
  .take_code_o  (take_code_o)
);

// File: tb/intr_select_tb_top.sv
module intr_select_tb_top;
  localparam int N = 13;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] src_set = '0, src_clr = '0;
  logic ee = 0, ce = 0, hv_mode = 0, hv_cap = 0, ext_route = 1, hdec_en = 0;
  logic dec_cfg = 1, pwr_save = 0;
  logic msg_valid = 0, msg_clear = 0, msg_bcast = 0;
  logic [2:0] msg_type = '0;
  logic [7:0] msg_tag = '0, core_id = 8'h5A;
  logic ready = 0;
  logic take_valid, req_active;
  logic [3:0] take_code;

  int n_run = 0, n_fail = 0, cyc = 0;

  always #4 clk = ~clk;

  intr_select dut_i (
    .clk(clk), .rst_n(rst_n), .src_set_i(src_set), .src_clr_i(src_clr),
    .ee_i(ee), .ce_i(ce), .hv_mode_i(hv_mode), .hv_cap_i(hv_cap),
    .ext_route_i(ext_route), .hdec_en_i(hdec_en), .dec_clr_take_i(dec_cfg),
    .pwr_save_i(pwr_save), .msg_valid_i(msg_valid), .msg_clear_i(msg_clear),
    .msg_type_i(msg_type), .msg_bcast_i(msg_bcast), .msg_tag_i(msg_tag),
    .core_id_i(core_id), .take_ready_i(ready), .take_valid_o(take_valid),
    .take_code_o(take_code), .req_active_o(req_active)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_set(input logic [N-1:0] m);
    @(negedge clk) src_set = m;
    @(negedge clk) src_set = '0;
  endtask

  task automatic pulse_clr(input logic [N-1:0] m);
    @(negedge clk) src_clr = m;
    @(negedge clk) src_clr = '0;
  endtask

  task automatic send_msg(input bit clr, input logic [2:0] ty, input bit bc, input logic [7:0] tg);
    @(negedge clk);
    msg_valid = 1; msg_clear = clr; msg_type = ty; msg_bcast = bc; msg_tag = tg;
    @(negedge clk);
    msg_valid = 0; msg_clear = 0; msg_bcast = 0;
  endtask

  task automatic wait_take(input int code, input string tag);
    int k = 0;
    while (!take_valid && k < 8) begin
      @(negedge clk);
      k++;
    end
    chk(take_valid === 1'b1, {tag, " valid"}, int'(take_valid), 1);
    chk(take_code === 4'(code), {tag, " code"}, int'(take_code), code);
  endtask

  task automatic accept();
    @(negedge clk) ready = 1;
    @(negedge clk) ready = 0;
  endtask

  task automatic expect_idle(input int n, input string tag);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (take_valid) seen = 1;
    end
    chk(!seen, tag, int'(seen), 0);
  endtask

  task automatic t_reset();
    chk(take_valid === 1'b0, "R1 reset valid", int'(take_valid), 0);
    chk(req_active === 1'b0, "R11 reset active", int'(req_active), 0);
  endtask

  task automatic t_latency();
    ee = 1; dec_cfg = 1;
    @(negedge clk) src_set = N'(1) << 9;
    @(negedge clk) src_set = '0;
    chk(take_valid === 1'b0, "R12 not yet valid", int'(take_valid), 0);
    chk(req_active === 1'b1, "R1 flag set", int'(req_active), 1);
    @(negedge clk);
    chk(take_valid === 1'b1 && take_code == 4'd9, "R12 valid after one edge", int'(take_code), 9);
    accept();
    chk(take_valid === 1'b0, "R10 gap after accept", int'(take_valid), 0);
    chk(req_active === 1'b0, "R11 active drops", int'(req_active), 0);
    expect_idle(3, "R7 dec cleared with config set");
    ee = 0;
  endtask

  task automatic t_priority();
    int order [11] = '{0, 1, 2, 5, 6, 7, 8, 9, 10, 11, 12};
    ee = 1; hdec_en = 1; dec_cfg = 1;
    pulse_set(13'h1FE7);
    foreach (order[i]) begin
      wait_take(order[i], $sformatf("R2 ladder step %0d", i));
      accept();
    end
    expect_idle(3, "R6 all cleared on take");
    chk(req_active === 1'b0, "R11 empty after ladder", int'(req_active), 0);
    ee = 0; hdec_en = 0;
    pulse_set((N'(1) << 0) | (N'(1) << 1) | (N'(1) << 5));
    wait_take(0, "R2 reset without enables");
    accept();
    wait_take(1, "R2 mcheck without enables");
    accept();
    expect_idle(4, "R5 watchdog blocked ee=0");
    ee = 1;
    wait_take(5, "R5 watchdog with ee");
    accept();
    ee = 0;
  endtask

  task automatic t_ext_sticky();
    ee = 1;
    pulse_set(N'(1) << 3);
    wait_take(3, "R6 ext first");
    accept();
    wait_take(3, "R6 ext again not cleared");
    pulse_clr(N'(1) << 3);
    accept();
    expect_idle(3, "R1 ext cleared by source");
    ee = 0; ce = 1;
    pulse_set(N'(1) << 4);
    wait_take(4, "R5 cext with ce");
    accept();
    wait_take(4, "R6 cext stays");
    ce = 0;
    accept();
    expect_idle(3, "R5 cext blocked ce=0");
    pulse_clr(N'(1) << 4);
    chk(req_active === 1'b0, "R11 cext cleared", int'(req_active), 0);
  endtask

  task automatic t_hdec_gate();
    hdec_en = 0; ee = 1; hv_mode = 0;
    pulse_set(N'(1) << 2);
    expect_idle(4, "R3 hdec blocked enable off");
    ee = 0; hv_mode = 1; hdec_en = 1;
    expect_idle(4, "R3 hdec blocked hv and ee off");
    hv_mode = 0;
    wait_take(2, "R3 hdec when not hv");
    accept();
    hdec_en = 0;
    chk(req_active === 1'b0, "R6 hdec cleared", int'(req_active), 0);
  endtask

  task automatic t_ext_route();
    ee = 0; hv_cap = 1; hv_mode = 0; ext_route = 1;
    pulse_set(N'(1) << 3);
    expect_idle(4, "R4 ext blocked by route bit");
    hv_mode = 1; ext_route = 0;
    expect_idle(4, "R4 ext blocked in hv mode");
    hv_mode = 0;
    wait_take(3, "R4 ext routed without ee");
    hv_cap = 0;
    accept();
    expect_idle(4, "R4 ext blocked without hv support");
    pulse_clr(N'(1) << 3);
    ext_route = 1;
  endtask

  task automatic t_dec_cfg();
    ee = 1; dec_cfg = 0;
    pulse_set(N'(1) << 9);
    wait_take(9, "R7 dec first");
    accept();
    wait_take(9, "R7 dec kept with config clear");
    dec_cfg = 1;
    accept();
    expect_idle(3, "R7 dec cleared with config set");
    ee = 0;
  endtask

  task automatic t_pwr();
    hdec_en = 0; ee = 1;
    pulse_set(N'(1) << 2);
    chk(req_active === 1'b1, "R1 hdec pending", int'(req_active), 1);
    @(negedge clk) pwr_save = 1;
    @(negedge clk) pwr_save = 0;
    hdec_en = 1;
    expect_idle(4, "R8 hdec discarded");
    chk(req_active === 1'b0, "R8 no flag left", int'(req_active), 0);
    @(negedge clk) begin src_set = N'(1) << 2; pwr_save = 1; end
    @(negedge clk) begin src_set = '0; pwr_save = 0; end
    expect_idle(3, "R8 discard beats set");
    hdec_en = 0; ee = 0;
  endtask

  task automatic t_dbell();
    ee = 1;
    send_msg(0, 3'd0, 0, 8'h5A);
    wait_take(10, "R9 doorbell tag match");
    accept();
    send_msg(0, 3'd1, 1, 8'h00);
    wait_take(6, "R9 critical doorbell broadcast");
    accept();
    send_msg(0, 3'd2, 1, 8'h5A);
    expect_idle(3, "R9 other type ignored");
    chk(req_active === 1'b0, "R9 other type no flag", int'(req_active), 0);
    send_msg(0, 3'd0, 0, 8'h11);
    expect_idle(3, "R9 tag mismatch ignored");
    ee = 0;
    send_msg(0, 3'd0, 1, 8'h00);
    chk(req_active === 1'b1, "R9 doorbell pending", int'(req_active), 1);
    send_msg(1, 3'd0, 0, 8'h5A);
    chk(req_active === 1'b0, "R9 clear message", int'(req_active), 0);
    ee = 1;
    expect_idle(3, "R9 cleared doorbell not taken");
    ee = 0;
  endtask

  task automatic t_hold();
    ee = 1; dec_cfg = 1;
    pulse_set(N'(1) << 9);
    wait_take(9, "R10 dec presented");
    pulse_set(N'(1) << 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(take_valid === 1'b1 && take_code == 4'd9, "R10 held code", int'(take_code), 9);
    end
    @(negedge clk) ready = 1;
    @(negedge clk) ready = 0;
    chk(take_valid === 1'b0, "R10 one idle cycle", int'(take_valid), 0);
    @(negedge clk);
    chk(take_valid === 1'b1 && take_code == 4'd0, "R10 next pick reset", int'(take_code), 0);
    accept();
    ee = 0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        n_run++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=0", cyc);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_latency();
    t_priority();
    t_ext_sticky();
    t_hdec_gate();
    t_ext_route();
    t_dec_cfg();
    t_pwr();
    t_dbell();
    t_hold();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule